// File: doc/BRIEF.md
# Value-Triggered Probe Capture Unit

This block is an on-chip capture engine for debugging logic inside a larger design. It watches two probe inputs, a 1-bit narrow probe and an 8-bit wide probe, on the rising edge of the probed design's clock. Each probe has an enable and a compare value. Once the host has armed the unit, it waits until every enabled probe equals its compare value. From that cycle on it writes one 9-bit word per clock into internal memory until a parameterised depth is filled. The probes serve as both trigger and data, and nothing from before the trigger is kept.

A host-side controller drives the arm request and the compare settings. It polls the state and sample-count outputs and, once the run is complete, reads the stored words through a synchronous index/data port with one cycle of latency. A synchronous reset returns the unit to idle. A new arm request restarts a run from any state.

Top module: `probe_capture`

## Requirements
- R1: A synchronous active-high `rst` sampled at a rising edge sets the state to idle (code 0), the sample count to 0 and `rdData` to 0 after that edge. Memory contents are not cleared.
- R2: An `armReq` high at a rising edge (with `rst` low) sets the state to armed (code 1) and the count to 0 after that edge, whatever the previous state, including during a capture and after completion.
- R3: In idle, with `armReq` low, the state stays idle and the count stays 0 whatever the probe and compare inputs are.
- R4: In armed, with `armReq` low, the state stays armed and the count stays 0 for as long as the trigger condition is false at the sampling edge.
- R5: The trigger condition is the AND over both probes of (probe disabled, or probe value equal to its compare value). With both probes disabled, the unit triggers on the first edge after arming.
- R6: Each stored word is {narrow probe, wide probe}: bit 8 holds the narrow probe and bits 7:0 hold the wide probe. Index 0 holds the value sampled at the trigger edge, and index i holds the value sampled i cycles later.
- R7: In capturing (code 2), the count rises by one on every edge. The edge that writes index DEPTH-1 moves the state to done (code 3) with the count equal to DEPTH.
- R8: In done, with `armReq` low, the state stays done and the count stays DEPTH.
- R9: `rdData` is updated at each rising edge. If the state before that edge is done, it takes the word at index `rdAddr`. In every other state it takes 0.
- R10: `stateOut` uses the codes idle=0, armed=1, capturing=2, done=3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock; all sampling on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| armReq | input | 1 | Arm request, sampled each edge |
| narrowEn | input | 1 | Include the narrow probe in the trigger condition |
| narrowCmp | input | NARROW_W | Compare value for the narrow probe |
| wideEn | input | 1 | Include the wide probe in the trigger condition |
| wideCmp | input | WIDE_W | Compare value for the wide probe |
| probeNarrow | input | NARROW_W | Narrow probe (trigger and data) |
| probeWide | input | WIDE_W | Wide probe (trigger and data) |
| rdAddr | input | $clog2(DEPTH) | Sample index for readout |
| rdData | output | NARROW_W+WIDE_W | Stored word, one cycle after the index |
| stateOut | output | 2 | Current sequencer state code |
| sampleCount | output | $clog2(DEPTH+1) | Number of samples written in this run |

## Verification
The embedded properties check these rules on every cycle: the reset result, that an arm request always lands in the armed state, that idle, armed-without-trigger and done hold their state, that the count steps by one while capturing and never passes the depth, that done implies a full count, and that the read port outputs zero outside done. Other behaviour only shows up in the bench's scenarios, because it needs a known stimulus history: which probe combinations fire the trigger under each enable setting, which cycle becomes index 0, and the bit order and cycle-by-cycle contents of the stored words. A scoreboard compares every read-back word against the sequence of values the bench drove.

// File: rtl/probe_capture_pkg.sv
package probe_capture_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_CAPT  = 2'd2,
    ST_DONE  = 2'd3
  } capState_t;

  // strobes from sequencer to datapath
  typedef struct packed {
    logic wrEn;    // write current probe word, advance count
    logic cntClr;  // restart the run
    logic rdOpen;  // readout allowed this cycle
  } capStrobe_t;

endpackage

// File: rtl/capture_dpath.sv
module capture_dpath
  import probe_capture_pkg::*;
#(
  parameter int DEPTH    = 1024,
  parameter int NARROW_W = 1,
  parameter int WIDE_W   = 8,
  localparam int SW = NARROW_W + WIDE_W,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  capStrobe_t          strb,
  input  logic                narrowEn,
  input  logic [NARROW_W-1:0] narrowCmp,
  input  logic                wideEn,
  input  logic [WIDE_W-1:0]   wideCmp,
  input  logic [NARROW_W-1:0] probeNarrow,
  input  logic [WIDE_W-1:0]   probeWide,
  input  logic [AW-1:0]       rdAddr,
  output logic                trigHit,
  output logic                lastWrite,
  output logic [CW-1:0]       count,
  output logic [SW-1:0]       rdData
);

  logic [SW-1:0] sampleMem [DEPTH];
  logic [SW-1:0] probeWord;
  logic          narrowOk;
  logic          wideOk;

  // per-port compare; a disabled port never blocks the trigger
  assign narrowOk  = !narrowEn || (probeNarrow == narrowCmp);
  assign wideOk    = !wideEn   || (probeWide   == wideCmp);
  assign trigHit   = narrowOk && wideOk;

  assign probeWord = {probeNarrow, probeWide};
  assign lastWrite = (count == CW'(DEPTH - 1));

  always_ff @(posedge clk) begin
    if (rst || strb.cntClr) begin
      count <= '0;
    end else if (strb.wrEn) begin
      count <= count + CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (strb.wrEn) begin
      sampleMem[count[AW-1:0]] <= probeWord;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdData <= '0;
    end else if (strb.rdOpen) begin
      rdData <= sampleMem[rdAddr];
    end else begin
      rdData <= '0;
    end
  end

  // R7
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));

endmodule

// File: rtl/capture_ctrl.sv
module capture_ctrl
  import probe_capture_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       armReq,
  input  logic       trigHit,
  input  logic       lastWrite,
  output capState_t  state,
  output capStrobe_t strb
);

  capState_t stateNext;

  always_comb begin
    stateNext   = state;
    strb.wrEn   = 1'b0;
    strb.cntClr = 1'b0;
    strb.rdOpen = (state == ST_DONE);
    if (armReq) begin
      stateNext   = ST_ARMED;
      strb.cntClr = 1'b1;
    end else begin
      unique case (state)
        ST_IDLE:  stateNext = ST_IDLE;
        ST_ARMED: begin
          if (trigHit) begin
            strb.wrEn = 1'b1;
            stateNext = lastWrite ? ST_DONE : ST_CAPT;
          end
        end
        ST_CAPT: begin
          strb.wrEn = 1'b1;
          if (lastWrite) stateNext = ST_DONE;
        end
        ST_DONE:  stateNext = ST_DONE;
        default:  stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNext;
  end

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && !armReq) |=> state == ST_IDLE);

  // R2
  arm_entry_chk: assert property (@(posedge clk) disable iff (rst)
    armReq |=> state == ST_ARMED);

  // R4
  armed_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ARMED && !armReq && !trigHit) |=> state == ST_ARMED);

  // R8
  done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DONE && !armReq) |=> state == ST_DONE);

endmodule

// File: rtl/probe_capture.sv
module probe_capture
  import probe_capture_pkg::*;
#(
  parameter int DEPTH    = 1024,
  parameter int NARROW_W = 1,
  parameter int WIDE_W   = 8,
  localparam int SW = NARROW_W + WIDE_W,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                armReq,
  input  logic                narrowEn,
  input  logic [NARROW_W-1:0] narrowCmp,
  input  logic                wideEn,
  input  logic [WIDE_W-1:0]   wideCmp,
  input  logic [NARROW_W-1:0] probeNarrow,
  input  logic [WIDE_W-1:0]   probeWide,
  input  logic [AW-1:0]       rdAddr,
  output logic [SW-1:0]       rdData,
  output logic [1:0]          stateOut,
  output logic [CW-1:0]       sampleCount
);

  capState_t  seqState;
  capStrobe_t seqStrb;
  logic       trigHit;
  logic       lastWrite;

  capture_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .armReq    (armReq),
    .trigHit   (trigHit),
    .lastWrite (lastWrite),
    .state     (seqState),
    .strb      (seqStrb)
  );

  capture_dpath #(
    .DEPTH    (DEPTH),
    .NARROW_W (NARROW_W),
    .WIDE_W   (WIDE_W)
  ) u_dpath (
    .clk         (clk),
    .rst         (rst),
    .strb        (seqStrb),
    .narrowEn    (narrowEn),
    .narrowCmp   (narrowCmp),
    .wideEn      (wideEn),
    .wideCmp     (wideCmp),
    .probeNarrow (probeNarrow),
    .probeWide   (probeWide),
    .rdAddr      (rdAddr),
    .trigHit     (trigHit),
    .lastWrite   (lastWrite),
    .count       (sampleCount),
    .rdData      (rdData)
  );

  assign stateOut = seqState;

  // R1
  rst_state_chk: assert property (@(posedge clk)
    rst |=> (stateOut == 2'd0 && sampleCount == '0 && rdData == '0));

  // R7
  capt_step_chk: assert property (@(posedge clk) disable iff (rst)
    (stateOut == 2'd2 && !armReq) |=> sampleCount == $past(sampleCount) + CW'(1));

  // R8
  done_full_chk: assert property (@(posedge clk) disable iff (rst)
    stateOut == 2'd3 |-> sampleCount == CW'(DEPTH));

  // R9
  rd_gate_chk: assert property (@(posedge clk) disable iff (rst)
    stateOut != 2'd3 |=> rdData == '0);

endmodule

// File: tb/sim_probe_capture.sv
module sim_probe_capture;
  localparam int DEPTH = 32;
  localparam int AW    = $clog2(DEPTH);
  localparam int CW    = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst;
  logic          armReq;
  logic          narrowEn;
  logic [0:0]    narrowCmp;
  logic          wideEn;
  logic [7:0]    wideCmp;
  logic [0:0]    probeNarrow;
  logic [7:0]    probeWide;
  logic [AW-1:0] rdAddr;
  logic [8:0]    rdData;
  logic [1:0]    stateOut;
  logic [CW-1:0] sampleCount;

  always #2 clk = ~clk;

  probe_capture #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst(rst), .armReq(armReq),
    .narrowEn(narrowEn), .narrowCmp(narrowCmp),
    .wideEn(wideEn), .wideCmp(wideCmp),
    .probeNarrow(probeNarrow), .probeWide(probeWide),
    .rdAddr(rdAddr), .rdData(rdData),
    .stateOut(stateOut), .sampleCount(sampleCount)
  );

  typedef struct {
    logic [8:0] expWord;
    string      tag;
    int         addr;
  } rdItem_t;

  rdItem_t    sbQ[$];
  logic [8:0] expMem [DEPTH];
  int         errors = 0;
  int         checks = 0;
  bit         ended  = 0;

  task automatic finishRun();
    if (!ended) begin
      ended = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic checkStatus(string tag, logic [1:0] expState, int expCount);
    chk({tag, " state"}, 32'(stateOut), 32'(expState));
    chk({tag, " count"}, 32'(sampleCount), 32'(expCount));
  endtask

  // driver: one input setting, one rising edge, back at a falling edge
  task automatic step(logic b, logic [7:0] w);
    probeNarrow = b;
    probeWide   = w;
    @(negedge clk);
  endtask

  task automatic pulseArm();
    armReq = 1'b1;
    @(negedge clk);
    armReq = 1'b0;
  endtask

  task automatic readExp(int addr, logic [8:0] exp, string tag);
    rdItem_t it;
    rdAddr     = AW'(addr);
    it.expWord = exp;
    it.tag     = tag;
    it.addr    = addr;
    sbQ.push_back(it);
    @(negedge clk);
  endtask

  // monitor: pops one expected item per edge after the driver queued it
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sbQ.size() > 0) begin
        rdItem_t it;
        it = sbQ.pop_front();
        checks++;
        if (rdData !== it.expWord) begin
          errors++;
          $display("FAIL %s idx %0d: actual=%0h expected=%0h",
                   it.tag, it.addr, rdData, it.expWord);
        end
      end
    end
  end

  // starts at a falling edge in the armed state with the trigger about to hold
  task automatic capture(logic tb, logic [7:0] tw, logic [7:0] base, string tag);
    expMem[0] = {tb, tw};
    step(tb, tw);
    checkStatus({tag, " R7 first sample"}, 2'd2, 1);
    for (int i = 1; i < DEPTH; i++) begin
      logic       b;
      logic [7:0] w;
      b = i[0];
      w = base + 8'(i * 3);
      expMem[i] = {b, w};
      if (i == 5) begin
        rdAddr = '0;
        sbQ.push_back('{9'd0, {tag, " R9 gated while capturing"}, 0});
      end
      if (i == 9) checkStatus({tag, " R7 mid run"}, 2'd2, 9);
      step(b, w);
    end
    checkStatus({tag, " R7 R10 done"}, 2'd3, DEPTH);
  endtask

  task automatic readAll(string tag);
    for (int i = 0; i < DEPTH; i++) readExp(i, expMem[i], tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finishRun();
  end

  initial begin
    rst = 1'b1; armReq = 1'b0;
    narrowEn = 1'b0; narrowCmp = '0; wideEn = 1'b0; wideCmp = '0;
    probeNarrow = '0; probeWide = '0; rdAddr = '0;
    repeat (3) @(negedge clk);
    checkStatus("R1 reset", 2'd0, 0);
    chk("R1 rdData", 32'(rdData), 0);
    rst = 1'b0;

    // R3: both ports disabled (always match) but not armed
    for (int i = 0; i < 4; i++) step(i[0], 8'(i));
    checkStatus("R3 idle ignores probes", 2'd0, 0);
    readExp(3, 9'd0, "R9 idle read");

    // narrow-only trigger on value 0
    narrowEn = 1'b1; narrowCmp = 1'b0; wideEn = 1'b0;
    probeNarrow = 1'b1; probeWide = 8'h3A;
    pulseArm();
    checkStatus("R2 R10 arm from idle", 2'd1, 0);
    step(1'b1, 8'h3A); step(1'b1, 8'h00); step(1'b1, 8'hFF);
    checkStatus("R4 waiting narrow", 2'd1, 0);
    capture(1'b0, 8'h3A, 8'h10, "runA");
    readAll("R6 runA");
    step(1'b0, 8'h3A); step(1'b1, 8'h00); step(1'b0, 8'h55);
    checkStatus("R8 done holds", 2'd3, DEPTH);
    readExp(DEPTH - 1, expMem[DEPTH-1], "R8 R9 last word kept");

    // wide-only trigger, narrow probe must be ignored
    narrowEn = 1'b0; wideEn = 1'b1; wideCmp = 8'h5C;
    probeWide = 8'h00;
    pulseArm();
    checkStatus("R2 arm from done", 2'd1, 0);
    step(1'b0, 8'h5B); step(1'b1, 8'h5D); step(1'b0, 8'hDC); step(1'b1, 8'h1C);
    checkStatus("R4 R5 wide mismatch", 2'd1, 0);
    capture(1'b1, 8'h5C, 8'h80, "runB");
    readAll("R6 runB");

    // both enabled: AND of matches
    narrowEn = 1'b1; narrowCmp = 1'b1; wideEn = 1'b1; wideCmp = 8'hC3;
    probeNarrow = 1'b0; probeWide = 8'h00;
    pulseArm();
    step(1'b1, 8'h00); step(1'b0, 8'hC3); step(1'b1, 8'hC2);
    checkStatus("R5 partial match no trigger", 2'd1, 0);
    capture(1'b1, 8'hC3, 8'h44, "runC");
    readExp(0, expMem[0], "R5 R6 runC trigger word");
    readExp(DEPTH - 1, expMem[DEPTH-1], "R6 runC last");

    // both disabled: trigger on the first armed edge; re-arm mid-capture
    narrowEn = 1'b0; wideEn = 1'b0;
    pulseArm();
    step(1'b0, 8'h11);
    checkStatus("R5 both disabled fires", 2'd2, 1);
    step(1'b1, 8'h12); step(1'b0, 8'h13); step(1'b1, 8'h14);
    checkStatus("R7 partial run", 2'd2, 4);
    pulseArm();
    checkStatus("R2 re-arm during capture", 2'd1, 0);
    capture(1'b0, 8'h77, 8'h20, "runD");
    readExp(0, expMem[0], "R2 R6 runD restart at index 0");
    readExp(7, expMem[7], "R6 runD index 7");

    // reset while done
    rst = 1'b1;
    step(1'b0, 8'h00);
    rst = 1'b0;
    checkStatus("R1 reset from done", 2'd0, 0);
    chk("R1 rdData after reset", 32'(rdData), 0);
    readExp(7, 9'd0, "R9 read after reset");

    step(1'b0, 8'h00);
    step(1'b0, 8'h00);
    finishRun();
  end

endmodule